// File: doc/BRIEF.md
# Multi-Bank GPIO Register Decoder

This block is the top of a general-purpose I/O controller that serves up to 160 pins as five banks of 32. A single-cycle register bus reaches every bank through one address decoder. A write is taken on the rising clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high. Each bank owns ten word registers: output level with set and clear aliases, drive enable, synchronised input level, rising and falling edge enables with set and clear aliases, and an edge event register whose bits are cleared by writing 1.

Interrupts leave the block in 16-pin groups rather than per bank. Every bank feeds two half-bank lines, one for its low 16 pins and one for its high 16 pins. A global group enable register gates each line before it reaches the `grp_irq` outputs. An outside interrupt controller collects those outputs.

Top module: `gpio_mb_top`

## Requirements
- R1: Bank k (k from 0 to NBANKS-1) owns the ten words from byte offset 0x10 + 0x28*k. An access there reaches only bank k's registers and pins `32k` to `32k+31`.
- R2: An address that lies neither in a bank block nor at 0x08 reads 0, and a write to it changes no register. This covers 0x00, 0x04, 0x0C and everything from the end of the last block up.
- R3: The group enable register sits at offset 0x08, and bit n enables group n. Only 2*NBANKS bits exist, and the bits above them read 0. The register resets to 0.
- R4: Group 2k carries the low half (pins 0-15) of bank k, and group 2k+1 carries its high half (pins 16-31).
- R5: `grp_irq[n]` is 1 exactly when enable bit n is 1 and at least one event bit in its half-bank is set.
- R6: Block offset 0x04 loads the output level. Offset 0x08 sets the bits written as 1, and 0x0C clears the bits written as 1. All three read back the level, which drives `pin_out`.
- R7: Block offset 0x10 holds the drive enable, where 1 means the pin is driven. It appears on `pin_oe` and resets to 0.
- R8: Block offset 0x00 reads the pin level through SYNC_STAGES flip-flops (default 2). A change on the pin becomes readable after exactly that many rising edges.
- R9: The rising-edge enable is set through offset 0x14 and cleared through 0x18. The falling-edge enable is set through 0x1C and cleared through 0x20. Each alias reads back its mask. An edge on a pin whose enable is 0 records nothing.
- R10: Block offset 0x24 is the event register. An enabled edge sets its bit one edge after the synchronised level changes. Writing 1 clears a bit. When a clear and a new edge on the same bit fall in the same cycle, the bit stays set.
- R11: After reset, `pin_out`, `pin_oe`, `grp_irq` and every register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32*NBANKS | Pin levels from the pads |
| pin_out | output | 32*NBANKS | Output levels |
| pin_oe | output | 32*NBANKS | Drive enables |
| grp_irq | output | 2*NBANKS | Gated half-bank interrupt lines |

## Verification
The event register can be written to clear a bit in the same cycle that an enabled edge on that pin sets it. The bench provokes this by raising a pin whose event bit is already set, timed to the synchroniser depth. It then issues the write-1 clear so that the clear lands on exactly the edge where the new event is recorded. The bench judges the case by reading the event register and the group output afterwards: the bit must still be set and the group line still asserted.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;
   localparam int DATA_W        = 32;
   localparam int BANK_PINS     = 32;
   localparam int GRP_PINS      = 16;
   localparam int GRPS_PER_BANK = BANK_PINS / GRP_PINS;
   localparam int BLK_WORDS     = 10;
   localparam int BLK_BASE_WORD = 4;
   localparam int GEN_WORD      = 2;
   localparam int MAX_BANKS     = 5;
   localparam int MAX_SYNC      = 4;

   typedef enum logic [3:0] {
      RG_LEVEL = 4'd0,
      RG_OUT   = 4'd1,
      RG_OSET  = 4'd2,
      RG_OCLR  = 4'd3,
      RG_DRIVE = 4'd4,
      RG_RSET  = 4'd5,
      RG_RCLR  = 4'd6,
      RG_FSET  = 4'd7,
      RG_FCLR  = 4'd8,
      RG_EVT   = 4'd9
   } bank_reg_e;
endpackage

// File: rtl/gpio_mb_decode.sv
module gpio_mb_decode
   import gpio_mb_pkg::*;
#(
   parameter int NBANKS = 5,
   parameter int WA_W   = 6
) (
   input  logic              sel,
   input  logic [WA_W-1:0]   waddr,
   output logic [NBANKS-1:0] bank_hit,
   output bank_reg_e         reg_idx,
   output logic              gen_hit,
   output logic              mapped
);
   localparam int END_WORD = BLK_BASE_WORD + NBANKS * BLK_WORDS;

   if (WA_W < 4 || END_WORD >= (1 << WA_W)) begin : g_bad_width
      $error("gpio_mb_decode: address too narrow for %0d banks", NBANKS);
   end

   logic [3:0] offs [NBANKS];

   for (genvar k = 0; k < NBANKS; k++) begin : g_blk
      localparam logic [WA_W-1:0] LO = WA_W'(BLK_BASE_WORD + k * BLK_WORDS);
      localparam logic [WA_W-1:0] HI = WA_W'(BLK_BASE_WORD + (k + 1) * BLK_WORDS);
      assign bank_hit[k] = sel && (waddr >= LO) && (waddr < HI);
      assign offs[k]     = 4'(waddr - LO);
   end

   logic [3:0] idx_raw;
   always_comb begin
      idx_raw = '0;
      for (int k = 0; k < NBANKS; k++) begin
         if (bank_hit[k]) idx_raw = idx_raw | offs[k];
      end
   end

   assign reg_idx = bank_reg_e'(idx_raw);
   assign gen_hit = sel && (waddr == WA_W'(GEN_WORD));
   assign mapped  = gen_hit || (|bank_hit);
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
   import gpio_mb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  bank_reg_e                idx,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic [BANK_PINS-1:0]     pin_in,
   output logic [BANK_PINS-1:0]     pin_out,
   output logic [BANK_PINS-1:0]     pin_oe,
   output logic [GRPS_PER_BANK-1:0] half_irq
);
   if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
      $error("gpio_mb_bank: SYNC_STAGES %0d out of range", SYNC_STAGES);
   end

   logic [BANK_PINS-1:0] level;
   logic [BANK_PINS-1:0] prev_q;
   logic [BANK_PINS-1:0] out_q, drive_q, rise_en_q, fall_en_q, evt_q;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign level = pin_in;
   end else begin : g_sync
      logic [BANK_PINS-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= pin_in;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign level = stg[SYNC_STAGES-1];
   end

   logic [BANK_PINS-1:0] rise_seen, fall_seen, evt_new, evt_clr;
   assign rise_seen = level & ~prev_q;
   assign fall_seen = ~level & prev_q;
   assign evt_new   = (rise_seen & rise_en_q) | (fall_seen & fall_en_q);
   assign evt_clr   = (wr_en && idx == RG_EVT) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         out_q     <= '0;
         drive_q   <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         evt_q     <= '0;
      end else begin
         prev_q <= level;
         evt_q  <= (evt_q & ~evt_clr) | evt_new;
         if (wr_en) begin
            unique case (idx)
               RG_OUT:   out_q     <= wdata;
               RG_OSET:  out_q     <= out_q | wdata;
               RG_OCLR:  out_q     <= out_q & ~wdata;
               RG_DRIVE: drive_q   <= wdata;
               RG_RSET:  rise_en_q <= rise_en_q | wdata;
               RG_RCLR:  rise_en_q <= rise_en_q & ~wdata;
               RG_FSET:  fall_en_q <= fall_en_q | wdata;
               RG_FCLR:  fall_en_q <= fall_en_q & ~wdata;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (idx)
         RG_LEVEL:                rdata = level;
         RG_OUT, RG_OSET, RG_OCLR: rdata = out_q;
         RG_DRIVE:                rdata = drive_q;
         RG_RSET, RG_RCLR:        rdata = rise_en_q;
         RG_FSET, RG_FCLR:        rdata = fall_en_q;
         RG_EVT:                  rdata = evt_q;
         default:                 rdata = '0;
      endcase
   end

   for (genvar h = 0; h < GRPS_PER_BANK; h++) begin : g_half
      assign half_irq[h] = |evt_q[h*GRP_PINS +: GRP_PINS];
   end

   assign pin_out = out_q;
   assign pin_oe  = drive_q;

   // R10
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_new) |=> ((evt_q & $past(evt_new)) == $past(evt_new)));

   // R6
   oset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == RG_OSET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

   // R6
   oclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == RG_OCLR) |=> ((pin_out & $past(wdata)) == '0));

   // R10
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == RG_EVT && evt_new == '0) |=> ((evt_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_mb_irqgate.sv
module gpio_mb_irqgate
   import gpio_mb_pkg::*;
#(
   parameter int NGRP = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NGRP-1:0]   wdata,
   input  logic [NGRP-1:0]   half_irq,
   output logic [DATA_W-1:0] gen_rd,
   output logic [NGRP-1:0]   grp_irq
);
   if (NGRP < 1 || NGRP > DATA_W) begin : g_bad_grp
      $error("gpio_mb_irqgate: NGRP %0d out of range", NGRP);
   end

   logic [NGRP-1:0] gen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gen_q <= '0;
      else if (wr_en) gen_q <= wdata;
   end

   assign gen_rd  = DATA_W'(gen_q);
   assign grp_irq = gen_q & half_irq;

   // R3
   gen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (gen_rd == DATA_W'($past(wdata))));

   // R5
   grp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_irq == '0) |-> (grp_irq == '0));
endmodule

// File: rtl/gpio_mb_top.sv
module gpio_mb_top
   import gpio_mb_pkg::*;
#(
   parameter int NBANKS      = 5,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NBANKS * BANK_PINS,
   localparam int NGRP       = NBANKS * GRPS_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NGRP-1:0]   grp_irq
);
   localparam int WA_W = ADDR_W - 2;

   if (NBANKS < 1 || NBANKS > MAX_BANKS) begin : g_bad_banks
      $error("gpio_mb_top: NBANKS %0d out of range", NBANKS);
   end

   logic              unused_lsb;
   logic [NBANKS-1:0] bank_hit;
   bank_reg_e         reg_idx;
   logic              gen_hit, mapped;
   logic [DATA_W-1:0] bank_rd [NBANKS];
   logic [DATA_W-1:0] gen_rd;
   logic [NGRP-1:0]   half_all;

   assign unused_lsb = ^bus_addr[1:0];

   gpio_mb_decode #(.NBANKS(NBANKS), .WA_W(WA_W)) u_dec (
      .sel      (bus_sel),
      .waddr    (bus_addr[ADDR_W-1:2]),
      .bank_hit (bank_hit),
      .reg_idx  (reg_idx),
      .gen_hit  (gen_hit),
      .mapped   (mapped)
   );

   for (genvar k = 0; k < NBANKS; k++) begin : g_bank
      gpio_mb_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_wr && bank_hit[k]),
         .idx      (reg_idx),
         .wdata    (bus_wdata),
         .rdata    (bank_rd[k]),
         .pin_in   (pin_in[k*BANK_PINS +: BANK_PINS]),
         .pin_out  (pin_out[k*BANK_PINS +: BANK_PINS]),
         .pin_oe   (pin_oe[k*BANK_PINS +: BANK_PINS]),
         .half_irq (half_all[k*GRPS_PER_BANK +: GRPS_PER_BANK])
      );
   end

   gpio_mb_irqgate #(.NGRP(NGRP)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && gen_hit),
      .wdata    (bus_wdata[NGRP-1:0]),
      .half_irq (half_all),
      .gen_rd   (gen_rd),
      .grp_irq  (grp_irq)
   );

   always_comb begin
      bus_rdata = gen_hit ? gen_rd : '0;
      for (int k = 0; k < NBANKS; k++) begin
         if (bank_hit[k]) bus_rdata = bus_rdata | bank_rd[k];
      end
   end

   // R1
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bank_hit, gen_hit}));

   // R2
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !mapped) |-> (bus_rdata == '0));

   // R3
   gen_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_hit |-> ((bus_rdata >> NGRP) == '0));
endmodule

// File: tb/tb_gpio_mb_top.sv
module tb_gpio_mb_top;
   localparam int NB    = 5;
   localparam int NPINS = NB * 32;
   localparam int NGRP  = NB * 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_sel = 1'b0;
   logic             bus_wr = 1'b0;
   logic [7:0]       bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NPINS-1:0] pin_in = '0;
   logic [NPINS-1:0] pin_out, pin_oe;
   logic [NGRP-1:0]  grp_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_mb_top #(.NBANKS(NB), .ADDR_W(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h14, 32'hA5A50F0F, 32'hA5A50F0F, 8'd6},  // R6 load
      '{1'b1, 8'h18, 32'h0000F000, 32'hA5A5FF0F, 8'd6},  // R6 set
      '{1'b1, 8'h1C, 32'hA0000000, 32'h05A5FF0F, 8'd6},  // R6 clear
      '{1'b1, 8'h3C, 32'h12345678, 32'h12345678, 8'd1},  // R1 bank 1
      '{1'b0, 8'h14, 32'h00000000, 32'h05A5FF0F, 8'd1},  // R1 bank 0 untouched
      '{1'b1, 8'hB4, 32'hDEADBEEF, 32'hDEADBEEF, 8'd1},  // R1 bank 4
      '{1'b1, 8'h08, 32'hFFFFFFFF, 32'h000003FF, 8'd3},  // R3 pad bits
      '{1'b1, 8'h08, 32'h00000000, 32'h00000000, 8'd3},  // R3
      '{1'b1, 8'hD8, 32'hFFFFFFFF, 32'h00000000, 8'd2},  // R2 past end
      '{1'b1, 8'h0C, 32'hFFFFFFFF, 32'h00000000, 8'd2},  // R2 hole
      '{1'b1, 8'h20, 32'h0000FFFF, 32'h0000FFFF, 8'd7},  // R7
      '{1'b1, 8'h24, 32'h00010001, 32'h00010001, 8'd9},  // R9 rise set
      '{1'b1, 8'h28, 32'h00000001, 32'h00010000, 8'd9},  // R9 rise clear
      '{1'b1, 8'h2C, 32'h80000000, 32'h80000000, 8'd9},  // R9 fall set
      '{1'b1, 8'h30, 32'h00000000, 32'h80000000, 8'd9},  // R9 fall clear
      '{1'b1, 8'h00, 32'hFFFFFFFF, 32'h00000000, 8'd2},  // R2 low hole
      '{1'b1, 8'hFC, 32'hFFFFFFFF, 32'h00000000, 8'd2}   // R2 top
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R11 reset state
      check("R11 pin_out", pin_out[31:0] | pin_out[159:128], 32'h0);
      check("R11 pin_oe", pin_oe[31:0], 32'h0);
      check("R11 grp_irq", 32'(grp_irq), 32'h0);
      bus_read(8'h08, rd); check("R11 enable reg", rd, 32'h0);
      bus_read(8'h34, rd); check("R11 event reg", rd, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
         bus_read(VECS[i].addr, rd);
         check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
      end

      // R1 / R2: pins reflect only intended banks; stray writes did nothing
      check("R1 bank0 pins", pin_out[31:0], 32'h05A5FF0F);
      check("R1 bank1 pins", pin_out[63:32], 32'h12345678);
      check("R1 bank2 pins", pin_out[95:64], 32'h0);
      check("R2 bank4 pins", pin_out[159:128], 32'hDEADBEEF);
      check("R7 drive pins", pin_oe[31:0], 32'h0000FFFF);
      check("R7 drive bank1", pin_oe[63:32], 32'h0);

      // R8 input latency of two edges
      @(negedge clk);
      pin_in[31:0] = 32'h0F0F1234;
      bus_read(8'h10, rd); check("R8 level after one edge", rd, 32'h0);
      bus_read(8'h10, rd); check("R8 level after two edges", rd, 32'h0F0F1234);
      idle(2);
      bus_read(8'h34, rd); check("R10 rising event", rd, 32'h00010000);
      check("R5 masked group", 32'(grp_irq), 32'h0);

      // R4 / R5 gating
      bus_write(8'h08, 32'h2);
      check("R4 high half to group 1", 32'(grp_irq), 32'h2);
      bus_write(8'h08, 32'h1);
      check("R5 enabled but idle group", 32'(grp_irq), 32'h0);
      bus_write(8'h08, 32'h3FF);
      check("R4 only group 1", 32'(grp_irq), 32'h2);

      // R10 clear
      bus_write(8'h34, 32'h00010000);
      bus_read(8'h34, rd); check("R10 write-one clear", rd, 32'h0);
      check("R10 group drops", 32'(grp_irq), 32'h0);

      // R9 falling edge on bit 16 not enabled
      @(negedge clk);
      pin_in[16] = 1'b0;
      idle(4);
      bus_read(8'h34, rd); check("R9 disabled fall ignored", rd, 32'h0);

      // R10 collision: new rising edge lands with the clear
      @(negedge clk);
      pin_in[16] = 1'b1;
      idle(4);
      bus_read(8'h34, rd); check("R10 event before collision", rd, 32'h00010000);
      @(negedge clk);
      pin_in[16] = 1'b0;
      idle(4);
      @(negedge clk);
      pin_in[16] = 1'b1;
      @(negedge clk);
      bus_write(8'h34, 32'h00010000);
      bus_read(8'h34, rd); check("R10 edge wins over clear", rd, 32'h00010000);
      check("R10 group stays up", 32'(grp_irq), 32'h2);

      // R9 enabled falling edge on bit 31
      bus_write(8'h34, 32'hFFFFFFFF);
      @(negedge clk);
      pin_in[31] = 1'b1;
      idle(4);
      bus_read(8'h34, rd); check("R9 rise on fall-only pin", rd, 32'h0);
      @(negedge clk);
      pin_in[31] = 1'b0;
      idle(4);
      bus_read(8'h34, rd); check("R9 falling event", rd, 32'h80000000);

      // R4 bank 2 low half feeds group 4
      bus_write(8'h74, 32'h00000008);
      @(negedge clk);
      pin_in[67] = 1'b1;
      idle(4);
      check("R4 group 4 and 1", 32'(grp_irq), 32'h012);
      bus_read(8'h84, rd); check("R1 bank2 event", rd, 32'h00000008);
      bus_read(8'h34, rd); check("R1 bank0 event unchanged", rd, 32'h80000000);

      // R11 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      #1;
      check("R11 grp after reset", 32'(grp_irq), 32'h0);
      check("R11 pins after reset", pin_out[159:128] | pin_oe[31:0], 32'h0);
      bus_read(8'h08, rd); check("R11 enable after reset", rd, 32'h0);
      bus_read(8'h24, rd); check("R11 rise enable after reset", rd, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule